// File: doc/BRIEF.md
# Cache Flush Sequencer

This block carries out a complete flush of a two-way set-associative data cache and of the instruction cache next to it. A flush starts on a rising edge of either the hardware flush pin or the software flush request. The sequencer then reads the line state of every set and way. Each line it finds in the Modified state is written back to memory as a burst of four 64-bit beats on a valid/ready write port. Lines in any other state cost no bus traffic.

When the last write-back has been accepted, the sequencer clears every set of both caches to Invalid, one set per cycle. It then presents a flush-acknowledge special cycle on its own valid/ready port. `busy_o` tells the rest of the core that a flush is in progress, and `done_o` marks the cycle in which it ends.

The write port follows the usual stream rules. Once `wb_valid_o` is high, the address, data and last flag stay unchanged until a cycle in which `wb_ready_i` is also high. The next beat is not offered until that transfer has happened. The acknowledge port follows the same rule. The state and data arrays return read data one cycle after the read strobe.

Top module: `cache_flush_seq`

## Requirements
- R1: When idle, a rising edge on `hw_flush_i` or on `sw_flush_i` starts a flush, and `busy_o` is high from the next cycle. A request input that stays high does not start a second flush.
- R2: Lines are visited with the set index ascending from 0 to 127, way 0 before way 1 in each set. Only lines with state code 2'b11 (Modified) produce bus beats. The state codes are Invalid=2'b00, Shared=2'b01, Exclusive=2'b10 and Modified=2'b11.
- R3: Each write-back is four beats. The address of beat b is {tag, set[6:0], b[1:0], 3'b000}, where tag is the 20-bit tag read with the line state. The data is the data array word for that set, way and beat. `wb_last_o` is high on beat 3 only.
- R4: While `wb_valid_o` is high and `wb_ready_i` is low, `wb_valid_o`, `wb_addr_o`, `wb_data_o` and `wb_last_o` hold their values. No beat is dropped or repeated.
- R5: Invalidation starts only after the last write-back beat has been accepted. Each set index from 0 to 127 is strobed on `inv_en_o`/`inv_set_o` exactly once, and each strobe clears all ways of that set in both caches.
- R6: The acknowledge cycle (`fack_valid_o`) is raised only after the last set has been invalidated. It stays high until `fack_ready_i` accepts it, and exactly one is issued per flush.
- R7: `busy_o` stays high until the cycle in which the acknowledge is accepted. In the cycle after that, `busy_o` is low and `done_o` is high for exactly one cycle.
- R8: A flush request that arrives while a flush is running is ignored. It causes no second scan and no second acknowledge.
- R9: After reset, `busy_o`, `done_o`, `wb_valid_o`, `inv_en_o` and `fack_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_flush_i | input | 1 | Hardware flush pin (acts on its rising edge) |
| sw_flush_i | input | 1 | Software flush request (acts on its rising edge) |
| busy_o | output | 1 | Flush in progress |
| done_o | output | 1 | One-cycle pulse after the acknowledge is accepted |
| st_rd_en_o | output | 1 | Line state read strobe |
| st_rd_set_o | output | 7 | Set index for the state read |
| st_rd_way_o | output | 1 | Way for the state read |
| st_rd_state_i | input | 2 | Line state, valid one cycle after the strobe |
| st_rd_tag_i | input | 20 | Line tag, valid one cycle after the strobe |
| dat_rd_en_o | output | 1 | Data array read strobe |
| dat_rd_set_o | output | 7 | Set index for the data read |
| dat_rd_way_o | output | 1 | Way for the data read |
| dat_rd_beat_o | output | 2 | Beat (64-bit word) within the line |
| dat_rd_data_i | input | 64 | Data word, valid one cycle after the strobe |
| inv_en_o | output | 1 | Invalidate all ways of a set in both caches |
| inv_set_o | output | 7 | Set index to invalidate |
| wb_valid_o | output | 1 | Write-back beat valid |
| wb_ready_i | input | 1 | Write-back beat accepted |
| wb_addr_o | output | 32 | Byte address of the beat |
| wb_data_o | output | 64 | Beat data |
| wb_last_o | output | 1 | Final beat of a line |
| fack_valid_o | output | 1 | Flush-acknowledge special cycle request |
| fack_ready_i | input | 1 | Flush-acknowledge accepted |

## Verification
The hardest case to reach from the ports combines two conditions. A Modified line sits at the very end of the scan, set 127, and the bus stalls in the middle of its burst. Only then can the invalidation or the acknowledge start early, or a held beat be lost. The stimulus places dirty lines at both ends of the index range and throttles `wb_ready_i` with an alternating pattern and a pseudo-random one. The bench records the cycle of the last accepted beat, the first and last invalidate strobes and the acknowledge, and compares their order. Extra requests are pulsed in the middle of a flush, and a request is held high across a whole flush, to show that neither starts another scan.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    LN_I = 2'b00,
    LN_S = 2'b01,
    LN_E = 2'b10,
    LN_M = 2'b11
  } line_st_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LOOK, SQ_EVAL, SQ_BURST, SQ_INVAL, SQ_ACK
  } seq_st_e;

  typedef enum logic [1:0] {
    B_IDLE, B_RD, B_CAP, B_SEND
  } burst_st_e;
endpackage

// File: rtl/cfs_trigger.sv
module cfs_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_i,
  input  logic sw_i,
  input  logic idle_i,
  output logic start_o
);
  logic hw_q, sw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_q <= 1'b0;
      sw_q <= 1'b0;
    end else begin
      hw_q <= hw_i;
      sw_q <= sw_i;
    end
  end

  // Only a fresh edge counts, and only while no flush is running.
  assign start_o = idle_i && ((hw_i && !hw_q) || (sw_i && !sw_q));
endmodule

// File: rtl/cfs_scan_ctr.sv
module cfs_scan_ctr #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_line_i,
  input  logic             step_set_i,
  output logic [SET_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o,
  output logic             last_line_o,
  output logic             last_set_o
);
  localparam logic [SET_W-1:0] SET_MAX = SET_W'(SETS - 1);
  localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(WAYS - 1);

  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      set_q <= '0;
      way_q <= '0;
    end else if (step_set_i) begin
      set_q <= set_q + 1'b1;
    end else if (step_line_i) begin
      if (way_q == WAY_MAX) begin
        way_q <= '0;
        set_q <= set_q + 1'b1;
      end else begin
        way_q <= way_q + 1'b1;
      end
    end
  end

  assign set_o       = set_q;
  assign way_o       = way_q;
  assign last_set_o  = (set_q == SET_MAX);
  assign last_line_o = (set_q == SET_MAX) && (way_q == WAY_MAX);

  // R2: after the highest way of a set, the scan moves to the next set
  assert_set_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_line_i && !step_set_i && !clr_i && way_q == WAY_MAX) |=>
      (way_q == '0) && (set_q == $past(set_q) + 1'b1));
endmodule

// File: rtl/cfs_burst.sv
module cfs_burst
  import cfs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  parameter int SET_W  = 7,
  parameter int WAY_W  = 1,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - SET_W - BEAT_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic              rd_en_o,
  output logic [SET_W-1:0]  rd_set_o,
  output logic [WAY_W-1:0]  rd_way_o,
  output logic [BEAT_W-1:0] rd_beat_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_last_o,
  output logic              done_o
);
  localparam logic [BEAT_W-1:0] BEAT_MAX = BEAT_W'(BEATS - 1);

  burst_st_e         st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SET_W-1:0]  set_q;
  logic [WAY_W-1:0]  way_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      beat_q <= '0;
      tag_q  <= '0;
      set_q  <= '0;
      way_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        B_IDLE: if (start_i) begin
          tag_q  <= tag_i;
          set_q  <= set_i;
          way_q  <= way_i;
          beat_q <= '0;
          st_q   <= B_RD;
        end
        B_RD:  st_q <= B_CAP;
        B_CAP: begin
          data_q <= rd_data_i;
          st_q   <= B_SEND;
        end
        B_SEND: if (wb_ready_i) begin
          if (beat_q == BEAT_MAX) begin
            st_q   <= B_IDLE;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
            st_q   <= B_RD;
          end
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign rd_en_o    = (st_q == B_RD);
  assign rd_set_o   = set_q;
  assign rd_way_o   = way_q;
  assign rd_beat_o  = beat_q;
  assign wb_valid_o = (st_q == B_SEND);
  assign wb_addr_o  = {tag_q, set_q, beat_q, {BYTE_W{1'b0}}};
  assign wb_data_o  = data_q;
  assign wb_last_o  = wb_valid_o && (beat_q == BEAT_MAX);
  assign done_o     = done_q;

  // R4: a stalled beat holds every field until it is accepted
  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) &&
      $stable(wb_data_o) && $stable(wb_last_o)));

  // R3: a burst ends only after its last beat was taken
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wb_valid_o && wb_ready_i && wb_last_o));

  // R3: each offered beat was fetched from the data array first
  assert_fetch_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid_o) |-> $past(rd_en_o, 2));
endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
  import cfs_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  parameter int BEATS  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - SET_W - BEAT_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_flush_i,
  input  logic              sw_flush_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              st_rd_en_o,
  output logic [SET_W-1:0]  st_rd_set_o,
  output logic [WAY_W-1:0]  st_rd_way_o,
  input  logic [1:0]        st_rd_state_i,
  input  logic [TAG_W-1:0]  st_rd_tag_i,
  output logic              dat_rd_en_o,
  output logic [SET_W-1:0]  dat_rd_set_o,
  output logic [WAY_W-1:0]  dat_rd_way_o,
  output logic [BEAT_W-1:0] dat_rd_beat_o,
  input  logic [DATA_W-1:0] dat_rd_data_i,
  output logic              inv_en_o,
  output logic [SET_W-1:0]  inv_set_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_last_o,
  output logic              fack_valid_o,
  input  logic              fack_ready_i
);
  seq_st_e          seq_q, seq_d;
  logic             start, ctr_clr, step_line, step_set, burst_go, burst_done;
  logic             last_line, last_set, done_q;
  logic [SET_W-1:0] set_idx;
  logic [WAY_W-1:0] way_idx;

  cfs_trigger u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_i    (hw_flush_i),
    .sw_i    (sw_flush_i),
    .idle_i  (seq_q == SQ_IDLE),
    .start_o (start)
  );

  cfs_scan_ctr #(.SETS(SETS), .WAYS(WAYS)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (ctr_clr),
    .step_line_i (step_line),
    .step_set_i  (step_set),
    .set_o       (set_idx),
    .way_o       (way_idx),
    .last_line_o (last_line),
    .last_set_o  (last_set)
  );

  cfs_burst #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS),
    .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (burst_go),
    .tag_i      (st_rd_tag_i),
    .set_i      (set_idx),
    .way_i      (way_idx),
    .rd_en_o    (dat_rd_en_o),
    .rd_set_o   (dat_rd_set_o),
    .rd_way_o   (dat_rd_way_o),
    .rd_beat_o  (dat_rd_beat_o),
    .rd_data_i  (dat_rd_data_i),
    .wb_valid_o (wb_valid_o),
    .wb_ready_i (wb_ready_i),
    .wb_addr_o  (wb_addr_o),
    .wb_data_o  (wb_data_o),
    .wb_last_o  (wb_last_o),
    .done_o     (burst_done)
  );

  always_comb begin
    seq_d        = seq_q;
    ctr_clr      = 1'b0;
    step_line    = 1'b0;
    step_set     = 1'b0;
    burst_go     = 1'b0;
    st_rd_en_o   = 1'b0;
    inv_en_o     = 1'b0;
    fack_valid_o = 1'b0;
    case (seq_q)
      SQ_IDLE: if (start) begin
        ctr_clr = 1'b1;
        seq_d   = SQ_LOOK;
      end
      SQ_LOOK: begin
        st_rd_en_o = 1'b1;
        seq_d      = SQ_EVAL;
      end
      SQ_EVAL: begin
        if (st_rd_state_i == LN_M) begin
          burst_go = 1'b1;
          seq_d    = SQ_BURST;
        end else if (last_line) begin
          ctr_clr = 1'b1;
          seq_d   = SQ_INVAL;
        end else begin
          step_line = 1'b1;
          seq_d     = SQ_LOOK;
        end
      end
      SQ_BURST: if (burst_done) begin
        if (last_line) begin
          ctr_clr = 1'b1;
          seq_d   = SQ_INVAL;
        end else begin
          step_line = 1'b1;
          seq_d     = SQ_LOOK;
        end
      end
      SQ_INVAL: begin
        inv_en_o = 1'b1;
        if (last_set) seq_d = SQ_ACK;
        else          step_set = 1'b1;
      end
      SQ_ACK: begin
        fack_valid_o = 1'b1;
        if (fack_ready_i) seq_d = SQ_IDLE;
      end
      default: seq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      done_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      done_q <= (seq_q == SQ_ACK) && fack_ready_i;
    end
  end

  assign st_rd_set_o = set_idx;
  assign st_rd_way_o = way_idx;
  assign inv_set_o   = set_idx;
  assign busy_o      = (seq_q != SQ_IDLE);
  assign done_o      = done_q;

  // R5: no invalidation while any write-back traffic is in flight
  assert_inv_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en_o |-> (!wb_valid_o && !dat_rd_en_o));

  // R6: the acknowledge request is held until taken
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fack_valid_o && !fack_ready_i) |=> fack_valid_o);

  // R6: the acknowledge follows the strobe of the final set
  assert_ack_after_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fack_valid_o) |-> ($past(inv_en_o) && $past(inv_set_o) == SET_W'(SETS - 1)));

  // R7: every flush activity is covered by busy
  assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd_en_o || wb_valid_o || inv_en_o || fack_valid_o) |-> busy_o);

  // R7: the completion pulse lasts one cycle and busy is already low
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(fack_valid_o && fack_ready_i)) ##1 !done_o);
endmodule

// File: tb/sim_cache_flush_seq.sv
`timescale 1ns/1ps
module sim_cache_flush_seq;
  localparam int SETS = 128;
  localparam int WAYS = 2;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        hw_flush, sw_flush, busy, done;
  logic        st_rd_en, dat_rd_en, inv_en, wb_valid, wb_last, fack_valid;
  logic [6:0]  st_rd_set, dat_rd_set, inv_set;
  logic        st_rd_way, dat_rd_way;
  logic [1:0]  dat_rd_beat;
  logic [1:0]  st_q;
  logic [19:0] tag_q;
  logic [63:0] data_q, wb_data;
  logic [31:0] wb_addr;
  logic        wb_ready, fack_ready;

  cache_flush_seq u0 (
    .clk(clk), .rst_n(rst_n), .hw_flush_i(hw_flush), .sw_flush_i(sw_flush),
    .busy_o(busy), .done_o(done),
    .st_rd_en_o(st_rd_en), .st_rd_set_o(st_rd_set), .st_rd_way_o(st_rd_way),
    .st_rd_state_i(st_q), .st_rd_tag_i(tag_q),
    .dat_rd_en_o(dat_rd_en), .dat_rd_set_o(dat_rd_set), .dat_rd_way_o(dat_rd_way),
    .dat_rd_beat_o(dat_rd_beat), .dat_rd_data_i(data_q),
    .inv_en_o(inv_en), .inv_set_o(inv_set),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_addr_o(wb_addr),
    .wb_data_o(wb_data), .wb_last_o(wb_last),
    .fack_valid_o(fack_valid), .fack_ready_i(fack_ready)
  );

  // vector: [12:11] line pattern, [10] use hw pin, [9:8] ready mode, [7:0] expected beats
  localparam logic [12:0] VEC [5] = '{
    {2'd0, 1'b0, 2'd0, 8'd0},
    {2'd1, 1'b1, 2'd1, 8'd8},
    {2'd2, 1'b0, 2'd2, 8'd64},
    {2'd3, 1'b1, 2'd2, 8'd104},
    {2'd1, 1'b0, 2'd0, 8'd8}
  };

  int errors = 0, checks = 0;
  int cyc = 0;

  logic [1:0]  dc_st [SETS][WAYS];
  logic        ic_v  [SETS][WAYS];
  int          inv_cnt [SETS];
  logic [31:0] cap_addr [256];
  logic [63:0] cap_data [256];
  logic        cap_last [256];
  int          n_cap, first_inv, last_inv, last_wb, ack_cnt, ack_cyc, done_cnt, hold_viol;
  int          fwait;
  logic [1:0]  rmode;
  logic [15:0] lfsr;
  logic        prev_stall;
  logic [31:0] p_addr;
  logic [63:0] p_data;

  function automatic logic [19:0] tag_fn(int s, int w);
    return 20'(s * 5 + w * 1000 + 'h31000);
  endfunction

  function automatic logic [63:0] data_fn(int s, int w, int b);
    return {8'hD0, 8'(w), 16'(s), 16'(b), 16'(s) ^ 16'h5A5A};
  endfunction

  function automatic logic [1:0] pat_fn(int p, int s, int w);
    case (p)
      0: return 2'((s + w) % 3);
      1: return ((s == 0 && w == 1) || (s == 127 && w == 0)) ? 2'b11 : 2'b10;
      2: return (s % 16 == 3) ? 2'b11 : 2'b01;
      default: return (s % 5 == 0 && w == 0) ? 2'b11 : (((s + w) % 2) ? 2'b01 : 2'b00);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor and models, all at the falling edge, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    case (rmode)
      2'd0: wb_ready = 1'b1;
      2'd1: wb_ready = ~wb_ready;
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wb_ready = lfsr[0];
      end
    endcase
    if (fack_valid) fwait++; else fwait = 0;
    fack_ready = fack_valid && (fwait >= 3);
    if (st_rd_en) begin
      st_q  <= dc_st[st_rd_set][st_rd_way];
      tag_q <= tag_fn(int'(st_rd_set), int'(st_rd_way));
    end
    if (dat_rd_en) data_q <= data_fn(int'(dat_rd_set), int'(dat_rd_way), int'(dat_rd_beat));
    if (inv_en) begin
      for (int w = 0; w < WAYS; w++) begin
        dc_st[inv_set][w] = 2'b00;
        ic_v[inv_set][w]  = 1'b0;
      end
      inv_cnt[inv_set]++;
      if (first_inv < 0) first_inv = cyc;
      last_inv = cyc;
    end
    if (prev_stall && (!wb_valid || wb_addr != p_addr || wb_data != p_data)) hold_viol++;
    prev_stall = wb_valid && !wb_ready;
    p_addr = wb_addr;
    p_data = wb_data;
    if (wb_valid && wb_ready) begin
      if (n_cap < 256) begin
        cap_addr[n_cap] = wb_addr;
        cap_data[n_cap] = wb_data;
        cap_last[n_cap] = wb_last;
      end
      n_cap++;
      last_wb = cyc;
    end
    if (fack_valid && fack_ready) begin
      ack_cnt++;
      ack_cyc = cyc;
    end
    if (done) done_cnt++;
  end

  task automatic load(input int p);
    for (int s = 0; s < SETS; s++) begin
      inv_cnt[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        dc_st[s][w] = pat_fn(p, s, w);
        ic_v[s][w]  = 1'b1;
      end
    end
    n_cap = 0; first_inv = -1; last_inv = -1; last_wb = -1;
  endtask

  task automatic run_flush(input int p, input bit use_hw, input logic [1:0] mode,
                           input int exp_beats, input bit disturb, input bit hold_req);
    int a0, d0, k, bad_seq, bad_inv;
    load(p);
    @(negedge clk);
    rmode = mode;
    a0 = ack_cnt; d0 = done_cnt;
    if (use_hw) hw_flush = 1'b1; else sw_flush = 1'b1;
    @(posedge clk); #2;
    chk(busy == 1'b1, "R1", "busy after request", busy, 1);
    @(negedge clk);
    if (!hold_req) begin hw_flush = 1'b0; sw_flush = 1'b0; end
    if (disturb) begin
      repeat (40) @(negedge clk);
      hw_flush = 1'b1; sw_flush = 1'b1;
      @(negedge clk);
      hw_flush = 1'b0; sw_flush = 1'b0;
    end
    do begin @(posedge clk); #2; end while (ack_cnt == a0);
    chk(busy == 1'b0 && done == 1'b1, "R7", "busy low and done high after ack", {busy, done}, 1);
    @(posedge clk); #2;
    chk(done == 1'b0, "R7", "done is one cycle", done, 0);
    // R2 R3: expected beat stream from the scan order
    k = 0; bad_seq = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (pat_fn(p, s, w) == 2'b11)
          for (int b = 0; b < 4; b++) begin
            if (k < n_cap && k < 256) begin
              if (cap_addr[k] != {tag_fn(s, w), 7'(s), 2'(b), 3'b000} ||
                  cap_data[k] != data_fn(s, w, b) || cap_last[k] != (b == 3)) begin
                if (bad_seq == 0)
                  $display("FAIL R3 beat %0d: actual addr=%h expected addr=%h",
                           k, cap_addr[k], {tag_fn(s, w), 7'(s), 2'(b), 3'b000});
                bad_seq++;
              end
            end
            k++;
          end
    chk(n_cap == exp_beats, "R2", "write-back beat count", n_cap, exp_beats);
    chk(bad_seq == 0, "R3", "beat address/data/last mismatches", bad_seq, 0);
    chk(hold_viol == 0, "R4", "stalled beat changes", hold_viol, 0);
    bad_inv = 0;
    for (int s = 0; s < SETS; s++) begin
      if (inv_cnt[s] != 1) bad_inv++;
      for (int w = 0; w < WAYS; w++)
        if (dc_st[s][w] != 2'b00 || ic_v[s][w]) bad_inv++;
    end
    chk(bad_inv == 0, "R5", "sets not invalidated exactly once in both caches", bad_inv, 0);
    chk(first_inv > last_wb, "R5", "first invalidate after last beat", first_inv, last_wb + 1);
    chk(ack_cnt == a0 + 1 && ack_cyc > last_inv, "R6", "single ack after last invalidate",
        ack_cnt - a0, 1);
    if (disturb || hold_req) begin
      repeat (30) @(negedge clk);
      chk(busy == 1'b0 && ack_cnt == a0 + 1 && done_cnt == d0 + 1, "R8",
          "no extra flush from ignored request", ack_cnt - a0, 1);
      hw_flush = 1'b0; sw_flush = 1'b0;
    end
  endtask

  initial begin
    hw_flush = 1'b0; sw_flush = 1'b0;
    rmode = 2'd0; wb_ready = 1'b1; fack_ready = 1'b0; fwait = 0;
    lfsr = 16'hACE1; prev_stall = 1'b0; p_addr = '0; p_data = '0;
    st_q = 2'b00; tag_q = '0; data_q = '0;
    ack_cnt = 0; ack_cyc = 0; done_cnt = 0; hold_viol = 0;
    load(0);
    repeat (4) @(negedge clk);
    // R9: reset values
    chk(!busy && !done && !wb_valid && !inv_en && !fack_valid, "R9", "outputs in reset",
        {busy, done, wb_valid, inv_en, fack_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !fack_valid, "R9", "idle after reset", busy, 0);

    foreach (VEC[i])
      run_flush(int'(VEC[i][12:11]), VEC[i][10], VEC[i][9:8], int'(VEC[i][7:0]), 1'b0, 1'b0);

    // R8: both requests pulsed mid-flush, bus stalling
    run_flush(1, 1'b0, 2'd2, 8, 1'b1, 1'b0);
    // R1: a request held high for the whole flush starts only one flush
    run_flush(2, 1'b1, 2'd1, 64, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule